// File: doc/BRIEF.md
# Sequential Power Unit Modulo 2^N

The block raises a base to an integer exponent and returns the low WIDTH bits of the exact result. Each operand has its own signedness input. When a flag is set, the operand is read as two's complement. When it is clear, the operand is read as a plain magnitude. A caller pulses `start_i` with the operands on the same cycle, then waits for the one-cycle `done_o` pulse. At that pulse it reads `result_o` and `invalid_o`.

Before any iteration, a decode step settles the degenerate cases:
- a zero base,
- a zero exponent,
- a negative exponent.

These cases finish at once. A positive exponent is handled by right-to-left square-and-multiply. The unit first takes the magnitude of the base and keeps every partial product modulo 2^WIDTH. Each exponent bit costs two clocks: one for the conditional multiply into the accumulator, and one for squaring the running power. Both steps share one multiplier. If the base was negative and the exponent is odd, the final value is negated.

Top module: `sqmul_pow`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `invalid_o` are 0 and `result_o` is 0.
- R2: A zero base with a negative exponent (exponent MSB set while `exp_signed_i` is 1) gives `invalid_o` = 1 and `result_o` = 0.
- R3: A zero base with a positive exponent gives 0 with `invalid_o` = 0.
- R4: A zero exponent gives 1 for any base, zero included.
- R5: With a negative exponent, a base whose magnitude exceeds one gives 0.
- R6: With a negative exponent, a base of +1 gives 1. A base of -1 (all ones with `base_signed_i` = 1) gives 1 for an even exponent and all ones for an odd exponent (bit 0 of the exponent set).
- R7: For a positive exponent, `result_o` equals base^exponent modulo 2^WIDTH. A clear signedness flag treats its operand's MSB as magnitude.
- R8: A negative base is raised by magnitude and the result is negated modulo 2^WIDTH when the exponent is odd.
- R9: `done_o` is high for exactly one cycle per accepted start. `busy_o` is high from the cycle after the start is sampled until `done_o`.
- R10: `result_o` and `invalid_o` change only in the cycle in which `done_o` is high.
- R11: `done_o` rises k clock edges after the edge that samples `start_i`. k = 1 for the cases of R2 to R6. k = 2L+1 for a positive exponent whose highest set bit is bit L-1.
- R12: A `start_i` pulse while `busy_o` is high is ignored, and the running computation completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a computation when idle |
| base_i | input | WIDTH | Base operand |
| exp_i | input | EXP_W | Exponent operand |
| base_signed_i | input | 1 | Read base as two's complement |
| exp_signed_i | input | 1 | Read exponent as two's complement |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | WIDTH | Result modulo 2^WIDTH, held between completions |
| invalid_o | output | 1 | Zero base raised to a negative power |

## Verification
The effects of a fault depend on where it sits:

- **Accumulator or squared-power register:** a corrupted value never heals. It reaches `result_o` at the next `done_o` as a wrong residue, often differing only in high bits, so the bench uses exponents long enough to spread errors across the whole word.
- **Exponent shift register:** a fault changes the completion time. The latency of every case is therefore checked to the exact edge, alongside the value.
- **Special-case decode:** a fault appears one edge after start as a wrong constant or a wrong invalid flag.
- **Operand capture while busy:** a fault shows up only if a second start arrives mid-run, so that stimulus is applied on purpose.

// File: rtl/sqmul_pkg.sv
package sqmul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_SQR  = 2'd2,
    ST_FIN  = 2'd3
  } sqmul_state_e;

endpackage

// File: rtl/sqmul_classify.sv
module sqmul_classify #(
  parameter int WIDTH = 16,
  parameter int EXP_W = 8
) (
  input  logic [WIDTH-1:0] base_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             base_signed_i,
  input  logic             exp_signed_i,
  output logic             special_o,
  output logic [WIDTH-1:0] spec_val_o,
  output logic             invalid_o,
  output logic             negate_o,
  output logic [WIDTH-1:0] base_mag_o
);

  localparam logic [WIDTH-1:0] ONE_W  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ONES_W = {WIDTH{1'b1}};

  function automatic logic [WIDTH-1:0] twos_neg(input logic [WIDTH-1:0] v);
    return (~v) + ONE_W;
  endfunction

  logic base_neg, exp_neg, base_zero, exp_zero, base_one, base_mone, exp_odd;

  always_comb begin
    base_neg  = base_signed_i & base_i[WIDTH-1];
    exp_neg   = exp_signed_i & exp_i[EXP_W-1];
    base_zero = (base_i == '0);
    exp_zero  = (exp_i == '0);
    base_mone = base_neg && (base_i == ONES_W);
    base_one  = (base_i == ONE_W) && !base_mone;
    exp_odd   = exp_i[0];
  end

  always_comb begin
    special_o  = 1'b1;
    spec_val_o = '0;
    invalid_o  = 1'b0;
    if (base_zero && exp_neg) begin
      invalid_o  = 1'b1;
    end else if (exp_zero) begin
      spec_val_o = ONE_W;
    end else if (base_zero) begin
      spec_val_o = '0;
    end else if (exp_neg) begin
      if (base_one)       spec_val_o = ONE_W;
      else if (base_mone) spec_val_o = exp_odd ? ONES_W : ONE_W;
      else                spec_val_o = '0;
    end else begin
      special_o  = 1'b0;
    end
  end

  assign negate_o   = base_neg & exp_odd;
  assign base_mag_o = base_neg ? twos_neg(base_i) : base_i;

endmodule

// File: rtl/sqmul_mult.sv
module sqmul_mult #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] p_o
);

  function automatic logic [WIDTH-1:0] mul_low(input logic [WIDTH-1:0] x,
                                               input logic [WIDTH-1:0] y);
    logic [WIDTH-1:0] r;
    r = x * y;
    return r;
  endfunction

  assign p_o = mul_low(a_i, b_i);

  // R7: the truncated product of two odd operands stays odd
  a_r7_odd_product: assert property (@(posedge clk) disable iff (!rst_n)
    (a_i[0] && b_i[0]) |-> p_o[0]);

  // R7: an operand of one passes the other through
  a_r7_unit_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (a_i == {{(WIDTH-1){1'b0}}, 1'b1}) |-> (p_o == b_i));

endmodule

// File: rtl/sqmul_pow.sv
module sqmul_pow
  import sqmul_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int EXP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] base_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             base_signed_i,
  input  logic             exp_signed_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o,
  output logic             invalid_o
);

  localparam logic [WIDTH-1:0] ONE_W = {{(WIDTH-1){1'b0}}, 1'b1};

  function automatic logic [WIDTH-1:0] fix_sign(input logic [WIDTH-1:0] v,
                                                input logic neg);
    return neg ? ((~v) + ONE_W) : v;
  endfunction

  sqmul_state_e     state_q;
  logic [WIDTH-1:0] acc_q, pw_q, res_q;
  logic [EXP_W-1:0] e_q;
  logic             neg_q, inv_pend_q, inv_q, done_q;

  // decoded operand view, exposed for the assertions
  logic             cls_special, cls_invalid, cls_negate;
  logic [WIDTH-1:0] cls_val, cls_mag;

  sqmul_classify #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_classify (
    .base_i       (base_i),
    .exp_i        (exp_i),
    .base_signed_i(base_signed_i),
    .exp_signed_i (exp_signed_i),
    .special_o    (cls_special),
    .spec_val_o   (cls_val),
    .invalid_o    (cls_invalid),
    .negate_o     (cls_negate),
    .base_mag_o   (cls_mag)
  );

  // shared multiplier: accumulator step or squaring step
  logic [WIDTH-1:0] mul_a, prod;
  logic             accept, step_mul, step_sqr, last_bit;

  assign mul_a    = (state_q == ST_SQR) ? pw_q : acc_q;
  assign accept   = (state_q == ST_IDLE) && start_i;
  assign step_mul = (state_q == ST_MUL) && e_q[0];
  assign step_sqr = (state_q == ST_SQR);
  assign last_bit = ((e_q >> 1) == '0);

  sqmul_mult #(.WIDTH(WIDTH)) u_mult (
    .clk  (clk),
    .rst_n(rst_n),
    .a_i  (mul_a),
    .b_i  (pw_q),
    .p_o  (prod)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      acc_q      <= '0;
      pw_q       <= '0;
      e_q        <= '0;
      neg_q      <= 1'b0;
      inv_pend_q <= 1'b0;
      res_q      <= '0;
      inv_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (cls_special) begin
              acc_q      <= cls_val;
              neg_q      <= 1'b0;
              inv_pend_q <= cls_invalid;
              state_q    <= ST_FIN;
            end else begin
              acc_q      <= ONE_W;
              pw_q       <= cls_mag;
              e_q        <= exp_i;
              neg_q      <= cls_negate;
              inv_pend_q <= 1'b0;
              state_q    <= ST_MUL;
            end
          end
        end
        ST_MUL: begin
          if (step_mul) acc_q <= prod;
          state_q <= ST_SQR;
        end
        ST_SQR: begin
          pw_q    <= prod;
          e_q     <= e_q >> 1;
          state_q <= last_bit ? ST_FIN : ST_MUL;
        end
        ST_FIN: begin
          res_q   <= fix_sign(acc_q, neg_q);
          inv_q   <= inv_pend_q;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign result_o  = res_q;
  assign invalid_o = inv_q;

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: no completion while still busy
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R10: outputs hold between completions
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(invalid_o)));

  // R2: an invalid result carries a zero value
  a_r2_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> (result_o == '0));

  // R2: the invalid decode is always one of the resolved cases
  a_r2_invalid_special: assert property (@(posedge clk) disable iff (!rst_n)
    cls_invalid |-> cls_special);

  // R12: a start during a run leaves the captured sign state untouched
  a_r12_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(neg_q) && $stable(inv_pend_q)));

  // R11: an accepted resolved case completes on the following edge
  a_r11_special_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cls_special) |=> (state_q == ST_FIN));

  // R7: the squaring step always precedes a new multiply step
  a_r7_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    (step_sqr && !last_bit) |=> (state_q == ST_MUL));

endmodule

// File: tb/test_sqmul_pow.sv
module test_sqmul_pow;

  localparam int W = 16;
  localparam int E = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] base_i = '0;
  logic [E-1:0] exp_i = '0;
  logic         base_signed_i = 1'b0;
  logic         exp_signed_i = 1'b0;
  logic         busy_o, done_o, invalid_o;
  logic [W-1:0] result_o;

  always #2.5 clk = ~clk;

  sqmul_pow #(.WIDTH(W), .EXP_W(E)) i_sqmul_pow (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .exp_i(exp_i), .base_signed_i(base_signed_i), .exp_signed_i(exp_signed_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .invalid_o(invalid_o)
  );

  typedef struct {
    logic [W-1:0] res;
    logic         inv;
    int           edge_n;
    int           lat;
    string        tag;
  } exp_item_t;

  exp_item_t q[$];
  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  logic [W-1:0] held_res = '0;
  logic         held_inv = 1'b0;
  bit           hold_bad = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input longint act, input longint expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // reference by repeated multiplication, independent of the iteration order
  task automatic model(input logic [W-1:0] b, input logic [E-1:0] e,
                       input logic bs, input logic es,
                       output logic [W-1:0] r, output logic inv, output int lat);
    longint a, x, acc;
    int len;
    a = longint'(b);
    if (bs && b[W-1]) a = a - (longint'(1) << W);
    x = longint'(e);
    if (es && e[E-1]) x = x - (longint'(1) << E);
    inv = 1'b0;
    lat = 1;
    if (a == 0 && x < 0) begin inv = 1'b1; r = '0; end
    else if (x == 0) r = 1;
    else if (a == 0) r = '0;
    else if (x < 0) begin
      if (a == 1) r = 1;
      else if (a == -1) r = (x % 2 != 0) ? '1 : W'(1);
      else r = '0;
    end else begin
      acc = 1;
      for (longint i = 0; i < x; i++) acc = (acc * a) & ((longint'(1) << W) - 1);
      r = W'(acc);
      len = 0;
      for (int i = 0; i < E; i++) if (e[i]) len = i + 1;
      lat = 2 * len + 1;
    end
  endtask

  task automatic issue(input logic [W-1:0] b, input logic [E-1:0] e,
                       input logic bs, input logic es, input bit poke,
                       input string tag);
    exp_item_t it;
    model(b, e, bs, es, it.res, it.inv, it.lat);
    it.tag = tag;
    @(negedge clk);
    base_i = b; exp_i = e; base_signed_i = bs; exp_signed_i = es;
    start_i = 1'b1;
    it.edge_n = cyc + 1;
    q.push_back(it);
    @(negedge clk);
    start_i = 1'b0;
    check({tag, " R9 busy after start"}, longint'(busy_o), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      base_i = 16'h0002; exp_i = 8'h01; base_signed_i = 1'b0; exp_signed_i = 1'b0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: scoreboard compare at each completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        if (q.size() == 0) begin
          check("R9 unexpected done", 1, 0);
        end else begin
          exp_item_t it;
          it = q.pop_front();
          check({it.tag, " result"}, longint'(result_o), longint'(it.res));
          check({it.tag, " invalid"}, longint'(invalid_o), longint'(it.inv));
          check({it.tag, " R11 latency"}, longint'(cyc - it.edge_n), longint'(it.lat));
          check({it.tag, " R10 hold"}, longint'(hold_bad), 0);
        end
        held_res = result_o;
        held_inv = invalid_o;
        hold_bad = 1'b0;
      end else if (result_o !== held_res || invalid_o !== held_inv) begin
        hold_bad = 1'b1;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done", longint'(done_o), 0);
    check("R1 busy", longint'(busy_o), 0);
    check("R1 result", longint'(result_o), 0);
    check("R1 invalid", longint'(invalid_o), 0);

    issue(16'd3,    8'd5,   1'b0, 1'b0, 1'b0, "R7 3^5");
    issue(16'd0,    8'hFF,  1'b0, 1'b1, 1'b0, "R2 0^-1");
    issue(16'd0,    8'd5,   1'b0, 1'b0, 1'b0, "R3 0^5");
    issue(16'd0,    8'h85,  1'b0, 1'b0, 1'b0, "R3 0^133 unsigned exp");
    issue(16'd7,    8'd0,   1'b1, 1'b1, 1'b0, "R4 7^0");
    issue(16'd0,    8'd0,   1'b1, 1'b1, 1'b0, "R4 0^0");
    issue(16'd5,    8'hFE,  1'b1, 1'b1, 1'b0, "R5 5^-2");
    issue(16'hFFFB, 8'hFF,  1'b1, 1'b1, 1'b0, "R5 -5^-1");
    issue(16'd1,    8'hFD,  1'b1, 1'b1, 1'b0, "R6 1^-3");
    issue(16'hFFFF, 8'hFD,  1'b1, 1'b1, 1'b0, "R6 -1^-3");
    issue(16'hFFFF, 8'hFE,  1'b1, 1'b1, 1'b0, "R6 -1^-2");
    issue(16'hFFFD, 8'd3,   1'b1, 1'b0, 1'b0, "R8 -3^3");
    issue(16'hFFFD, 8'd4,   1'b1, 1'b0, 1'b0, "R8 -3^4");
    issue(16'hFFFD, 8'd3,   1'b0, 1'b0, 1'b0, "R7 65533^3 unsigned");
    issue(16'd3,    8'hFF,  1'b0, 1'b0, 1'b0, "R7 3^255");
    issue(16'd3,    8'hFF,  1'b0, 1'b1, 1'b0, "R5 3^-1");
    issue(16'h8000, 8'd2,   1'b1, 1'b0, 1'b0, "R8 min^2");
    issue(16'h1235, 8'd77,  1'b1, 1'b0, 1'b0, "R7 0x1235^77");
    issue(16'hABCD, 8'd101, 1'b1, 1'b1, 1'b0, "R8 neg^101");
    issue(16'd3,    8'hFF,  1'b0, 1'b0, 1'b1, "R12 start while busy");
    check("R12 no extra result", longint'(q.size()), 0);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(100000 * 5);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=finish", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule